// File: doc/BRIEF.md
# Extended Branch Condition Evaluator

This block decides whether a conditional branch is taken. It looks at two register operands and a four-bit condition code, and gives one taken bit. It holds no flag or condition-code state: every decision comes from the two operands it sees.

Besides the usual signed and unsigned relational tests, it has truth tests that combine the operands. Each operand counts as true when it is nonzero. The block offers AND, OR and their inverted forms NAND and NOR, so that conditions like `if (x && y)` or `if (x || y)` need only one branch. It also has single-bit tests that branch when a chosen bit of the first operand is set or clear. The unit is purely combinational. Target address calculation, decode and prediction are done elsewhere.

Top module: `brcond_eval`

## Requirements
- R1: Code 0 (EQ) is taken exactly when the two operands are equal.
- R2: Code 1 (NE) is taken exactly when the two operands differ.
- R3: Code 2 (LT) is taken when operand A is less than operand B as two's-complement numbers. Code 3 (GE) is taken in the other case, including when they are equal.
- R4: Code 4 (LTU) is taken when A is less than B as unsigned numbers. Code 5 (GEU) is taken in the other case.
- R5: Code 6 (AND) is taken when both operands are nonzero.
- R6: Code 7 (OR) is taken when at least one operand is nonzero.
- R7: Code 8 (NAND) is the inverse of AND. Code 9 (NOR) is the inverse of OR.
- R8: Code 10 (bit set) is taken when bit k of operand A is 1. Code 11 (bit clear) is taken when that bit is 0. Here k is operand B bits [4:0], and the upper bits of operand B have no effect.
- R9: Codes 12 to 15 are never taken, whatever the operands.
- R10: The result depends only on the inputs present at that moment: no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand; the data word for the bit tests |
| opb_i | input | 32 | Second operand; bits [4:0] give the bit index for the bit tests |
| cond_i | input | 4 | Condition select code |
| taken_o | output | 1 | High when the branch is taken |

## Verification
The assertions assume only that the operands and the condition code are settled, known values. They check the unit each time its inputs change, so they need no clock and no reset. The bench changes its inputs only at falling clock edges and compares the result one time unit later, so each check sees settled values. The stimulus mixes random operands with zero, equal and sign-boundary operands, and with upper bits of operand B set during bit tests. Every one of the sixteen codes is driven.

// File: rtl/brcond_pkg.sv
// Shared definitions for the branch condition evaluator.
// Assumes a four-bit condition select. Codes not listed here are never taken.
package brcond_pkg;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        BC_EQ   = 4'd0,
        BC_NE   = 4'd1,
        BC_LT   = 4'd2,
        BC_GE   = 4'd3,
        BC_LTU  = 4'd4,
        BC_GEU  = 4'd5,
        BC_AND  = 4'd6,
        BC_OR   = 4'd7,
        BC_NAND = 4'd8,
        BC_NOR  = 4'd9,
        BC_BSET = 4'd10,
        BC_BCLR = 4'd11
    } cond_e;
endpackage

// File: rtl/brc_relational.sv
// Relational compare of two operands.
// One widened subtraction gives the unsigned less-than. The signed less-than
// comes from the same result, corrected when the operand signs differ.
// Assumes XLEN >= 2.
module brc_relational #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic            eq_o,
    output logic            lt_o,
    output logic            ltu_o
);
    localparam int DW = XLEN + 1;

    logic [DW-1:0] diff;

    // Borrow-out subtraction and equality.
    always_comb begin
        diff  = {1'b0, a_i} - {1'b0, b_i};
        eq_o  = (a_i == b_i);
        ltu_o = diff[DW-1];
    end

    // Signed order: when the signs differ, the negative operand is smaller.
    always_comb begin
        if (a_i[XLEN-1] != b_i[XLEN-1])
            lt_o = a_i[XLEN-1];
        else
            lt_o = diff[DW-1];
    end
endmodule

// File: rtl/brc_logical.sv
// Truth tests on two operands. A nonzero operand counts as true.
// Gives the AND and OR of the two truth values. The top inverts them when
// it needs the NAND and NOR forms.
module brc_logical #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic            both_o,
    output logic            any_o
);
    logic a_nz;
    logic b_nz;

    // Reduce each operand to a truth value and combine the two.
    always_comb begin
        a_nz   = |a_i;
        b_nz   = |b_i;
        both_o = a_nz & b_nz;
        any_o  = a_nz | b_nz;
    end
endmodule

// File: rtl/brc_bittest.sv
// Single-bit test: picks one bit of the data word. The low bits of the
// index operand give its position, and the upper index bits are ignored.
// Assumes XLEN is a power of two.
module brc_bittest #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] data_i,
    input  logic [XLEN-1:0] idx_i,
    output logic            set_o,
    output logic            clr_o
);
    localparam int IDX_W = $clog2(XLEN);

    logic [IDX_W-1:0] pos;
    logic [XLEN-1:0]  shifted;

    // Shift the chosen bit down to position zero and report both senses.
    always_comb begin
        pos     = idx_i[IDX_W-1:0];
        shifted = data_i >> pos;
        set_o   = shifted[0];
        clr_o   = ~shifted[0];
    end
endmodule

// File: rtl/brcond_eval.sv
// Branch condition evaluator (top).
// Combinational: it decodes the condition select and routes the matching
// compare, truth or bit-test result to taken_o. It holds no state.
// Assumes the inputs are settled within the cycle that uses the result.
module brcond_eval #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]               opa_i,
    input  logic [XLEN-1:0]               opb_i,
    input  logic [brcond_pkg::CODE_W-1:0] cond_i,
    output logic                          taken_o
);
    import brcond_pkg::*;

    logic rel_eq;
    logic rel_lt;
    logic rel_ltu;
    logic log_both;
    logic log_any;
    logic bit_set;
    logic bit_clr;

    brc_relational #(.XLEN(XLEN)) u_rel (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .eq_o  (rel_eq),
        .lt_o  (rel_lt),
        .ltu_o (rel_ltu)
    );

    brc_logical #(.XLEN(XLEN)) u_log (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .both_o (log_both),
        .any_o  (log_any)
    );

    brc_bittest #(.XLEN(XLEN)) u_bit (
        .data_i (opa_i),
        .idx_i  (opb_i),
        .set_o  (bit_set),
        .clr_o  (bit_clr)
    );

    // Select the result named by the condition code. Unused codes give not taken.
    always_comb begin
        case (cond_e'(cond_i))
            BC_EQ:   taken_o = rel_eq;
            BC_NE:   taken_o = ~rel_eq;
            BC_LT:   taken_o = rel_lt;
            BC_GE:   taken_o = ~rel_lt;
            BC_LTU:  taken_o = rel_ltu;
            BC_GEU:  taken_o = ~rel_ltu;
            BC_AND:  taken_o = log_both;
            BC_OR:   taken_o = log_any;
            BC_NAND: taken_o = ~log_both;
            BC_NOR:  taken_o = ~log_any;
            BC_BSET: taken_o = bit_set;
            BC_BCLR: taken_o = bit_clr;
            default: taken_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/brcond_eval_chk.sv
// Checker for the branch condition evaluator, attached by bind.
// Immediate assertions, evaluated whenever the inputs or results change.
module brcond_eval_chk #(
    parameter int XLEN = 32
) (
    input logic [XLEN-1:0] opa_i,
    input logic [XLEN-1:0] opb_i,
    input logic [3:0]      cond_i,
    input logic            taken_o,
    input logic            rel_eq,
    input logic            log_both,
    input logic            log_any,
    input logic            bit_set,
    input logic            bit_clr
);
    // Check the port and sub-unit relations on every change.
    always_comb begin
        if (cond_i == 4'd0)
            AST_EQ_MATCHES_OPERANDS: assert (taken_o == (opa_i == opb_i)) else $error("eq"); // R1
        if (cond_i == 4'd1)
            AST_NE_OPPOSES_EQ_UNIT: assert (taken_o == !rel_eq) else $error("ne"); // R2
        if (cond_i == 4'd3)
            AST_GE_SIGNED_ORDER: assert (taken_o == ($signed(opa_i) >= $signed(opb_i))) else $error("ge"); // R3
        if (cond_i == 4'd5)
            AST_GEU_UNSIGNED_ORDER: assert (taken_o == (opa_i >= opb_i)) else $error("geu"); // R4
        AST_AND_IMPLIES_OR: assert (!log_both || log_any) else $error("and/or"); // R5
        if (cond_i == 4'd8)
            AST_NAND_INVERTS_AND: assert (taken_o != log_both) else $error("nand"); // R7
        if (cond_i == 4'd9)
            AST_NOR_INVERTS_OR: assert (taken_o != log_any) else $error("nor"); // R7
        AST_BIT_SENSES_EXCLUSIVE: assert (bit_set != bit_clr) else $error("bit"); // R8
        if (cond_i >= 4'd12)
            AST_UNUSED_NOT_TAKEN: assert (!taken_o) else $error("unused"); // R9
    end
endmodule

bind brcond_eval brcond_eval_chk #(.XLEN(XLEN)) u_chk (
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .cond_i   (cond_i),
    .taken_o  (taken_o),
    .rel_eq   (rel_eq),
    .log_both (log_both),
    .log_any  (log_any),
    .bit_set  (bit_set),
    .bit_clr  (bit_clr)
);

// File: tb/tb_brcond_eval.sv
// Self-checking bench for brcond_eval. A behavioural reference is compared
// after every input change, and each change is made once per clock.
module tb_brcond_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opa;
    logic [31:0] opb;
    logic [3:0]  cond;
    logic        taken;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    brcond_eval dut (
        .opa_i   (opa),
        .opb_i   (opb),
        .cond_i  (cond),
        .taken_o (taken)
    );

    // Behavioural reference built from the requirement table.
    function automatic bit ref_taken(input logic [31:0] a, input logic [31:0] b, input int c);
        int  sa = int'(a);
        int  sb = int'(b);
        longint unsigned ua = longint'(a);
        longint unsigned ub = longint'(b);
        bit  ta = (a != 0);
        bit  tb = (b != 0);
        int  k  = int'(b) & 31;
        case (c)
            0: return a == b;
            1: return a != b;
            2: return sa < sb;
            3: return !(sa < sb);
            4: return ua < ub;
            5: return !(ua < ub);
            6: return ta && tb;
            7: return ta || tb;
            8: return !(ta && tb);
            9: return !(ta || tb);
            10: return ((a >> k) & 32'd1) == 32'd1;
            11: return ((a >> k) & 32'd1) == 32'd0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(input int c);
        case (c)
            0: return "R1";
            1: return "R2";
            2, 3: return "R3";
            4, 5: return "R4";
            6: return "R5";
            7: return "R6";
            8, 9: return "R7";
            10, 11: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic compare(input string tag, input bit expv);
        checks++;
        if (taken !== expv) begin
            errors++;
            $display("FAIL %s code=%0d a=%h b=%h actual=%b expected=%b",
                     tag, cond, opa, opb, taken, expv);
        end
    endtask

    // Drive at the falling edge and compare once the logic has settled (R10).
    task automatic apply(input logic [31:0] a, input logic [31:0] b, input int c);
        @(negedge clk);
        opa  = a;
        opb  = b;
        cond = 4'(c);
        #1;
        compare(tag_of(c), ref_taken(a, b, c));
    endtask

    initial begin
        opa = '0; opb = '0; cond = 4'd0;
        repeat (3) @(posedge clk);
        #1;
        compare("R1", 1'b1);   // reset period: zero operands are equal
        rst_n = 1'b1;

        // R1 / R2 equality edges
        apply(32'h1234_5678, 32'h1234_5678, 0);
        apply(32'h1234_5678, 32'h1234_5679, 0);
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
        apply(32'h0000_0000, 32'h8000_0000, 1);
        // R3 / R4 sign boundary: 0x80000000 vs 1 differ signed/unsigned
        apply(32'h8000_0000, 32'h0000_0001, 2);
        apply(32'h8000_0000, 32'h0000_0001, 4);
        apply(32'h8000_0000, 32'h0000_0001, 3);
        apply(32'h8000_0000, 32'h0000_0001, 5);
        apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, 3);   // R3 equal gives GE
        apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, 2);   // R3 equal is not LT
        apply(32'hFFFF_FFFF, 32'h0000_0000, 5);   // R4 max vs zero
        // R5 / R6 / R7 with a zero operand
        apply(32'h0000_0010, 32'h0000_0000, 6);
        apply(32'h0000_0010, 32'h8000_0000, 6);
        apply(32'h0000_0000, 32'h0000_0000, 7);
        apply(32'h0000_0000, 32'h0000_0001, 7);
        apply(32'h0000_0010, 32'h0000_0000, 8);
        apply(32'h0000_0000, 32'h0000_0000, 9);
        apply(32'h0000_0000, 32'h4000_0000, 9);
        // R8 bit 31, bit 0, upper index bits ignored
        apply(32'h8000_0000, 32'h0000_001F, 10);
        apply(32'h8000_0000, 32'hFFFF_FFE0, 10);
        apply(32'h0000_0001, 32'hFFFF_FFE0, 11);
        apply(32'hFFFF_FFFE, 32'h0000_0020, 11);
        // R9 unused codes with operands that would take other tests
        for (int c = 12; c < 16; c++) apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, c);

        // Random sweep over every code with biased operands.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a = $urandom;
            logic [31:0] b = $urandom;
            int sel = int'($urandom_range(0, 7));
            if (sel == 0) a = '0;
            if (sel == 1) b = '0;
            if (sel == 2) b = a;
            if (sel == 3) a = {1'b1, a[30:0]};
            apply(a, b, int'($urandom_range(0, 15)));
        end
        done = 1'b1;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog R10 actual=timeout expected=completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule